// File: doc/BRIEF.md
# Branch Resolution and Next-PC Unit

This unit resolves one jump-class instruction per issue. From the 8-bit opcode, the destination and source register values, the 32-bit immediate, the signed 16-bit offset and the current program counter, it decides whether a conditional branch is taken. It also produces the address of the next instruction slot. It pulses a call request or an exit request, and it flags encodings that are not legal.

The program counter counts 64-bit instruction slots. A sequential step adds one. A taken branch adds one plus the sign-extended offset. Results appear one clock after an issue. The flags are single-cycle pulses, and the next-PC output holds its last value between issues. The call target and the stack unwind belong to other logic. Call and exit only raise their request. Neither of them moves the PC beyond the sequential step.

Top module: `jmp_resolve_unit`

## Requirements
- R1: While reset is asserted, next_pc is zero and taken, call_req, exit_req and illegal are all low.
- R2: Results appear in the cycle after issue_valid is high. In any cycle after issue_valid was low, all four flags are low and next_pc keeps its previous value.
- R3: Opcode bits [2:0] select the width. Value 5 compares full 64-bit operands. Value 6 compares only bits [31:0] of each operand.
- R4: Opcode bit 3 selects the second operand: 1 takes src_val, 0 takes imm. In width 5 the immediate is sign-extended to 64 bits.
- R5: The unsigned relations use opcode bits [7:4]: 2 is greater, 3 is greater-or-equal, 10 is less and 11 is less-or-equal.
- R6: The signed two's-complement relations use bits [7:4]: 6 is greater, 7 is greater-or-equal, 12 is less and 13 is less-or-equal.
- R7: Bits [7:4] equal to 1 test equality, 5 tests inequality, and 4 is taken when dst AND operand is nonzero.
- R8: A taken branch gives next_pc = pc + 1 + sign-extended offset. A branch that is not taken gives pc + 1. Both wrap modulo 2^64.
- R9: Bits [7:4] equal to 0 in width 5 is always taken.
- R10: Code 8 (either width) pulses call_req with next_pc = pc + 1 and taken low. Code 9 in width 5 pulses exit_req with next_pc = pc + 1 and taken low.
- R11: The illegal flag is raised for codes 14 and 15, for code 0 or 9 in width 6, and for any width other than 5 or 6. When it is raised, next_pc equals pc and taken, call_req and exit_req are low. At most one flag is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 8 | Relation code [7:4], operand select [3], width class [2:0] |
| dst_val | input | 64 | Destination register value |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Immediate field |
| offset | input | 16 | Signed branch displacement in slots |
| pc_in | input | 64 | Current instruction slot address |
| next_pc | output | 64 | Resolved next slot address |
| taken | output | 1 | Branch taken pulse |
| call_req | output | 1 | Call request pulse |
| exit_req | output | 1 | Exit request pulse |
| illegal | output | 1 | Illegal encoding pulse |

## Verification
Each relation is given the same operands in pairs: a top-bit-set value against a small value, and negative against negative. The results show whether signed and unsigned paths are swapped and whether equality is counted at the boundary. Values that differ only above bit 31 tell the two widths apart. Negative immediates, with a register operand that disagrees with the immediate, show whether the immediate is sign-extended and how opcode bit 3 is decoded. Illegal codes, the width-6-only exclusions and offsets that wrap past zero and the top address check the PC arithmetic and the illegal path.

// File: rtl/jru_pkg.sv
package jru_pkg;
  localparam logic [2:0] CLS_WIDE   = 3'd5;
  localparam logic [2:0] CLS_NARROW = 3'd6;

  localparam logic [3:0] JC_ALWAYS = 4'd0;
  localparam logic [3:0] JC_EQ     = 4'd1;
  localparam logic [3:0] JC_GTU    = 4'd2;
  localparam logic [3:0] JC_GEU    = 4'd3;
  localparam logic [3:0] JC_TEST   = 4'd4;
  localparam logic [3:0] JC_NE     = 4'd5;
  localparam logic [3:0] JC_GTS    = 4'd6;
  localparam logic [3:0] JC_GES    = 4'd7;
  localparam logic [3:0] JC_CALL   = 4'd8;
  localparam logic [3:0] JC_EXIT   = 4'd9;
  localparam logic [3:0] JC_LTU    = 4'd10;
  localparam logic [3:0] JC_LEU    = 4'd11;
  localparam logic [3:0] JC_LTS    = 4'd12;
  localparam logic [3:0] JC_LES    = 4'd13;
  localparam logic [3:0] JC_LAST   = JC_LES;

  typedef struct packed {
    logic [3:0] code;
    logic       use_reg;
    logic       narrow;
    logic       illegal;
    logic       is_call;
    logic       is_exit;
    logic       is_always;
  } jdec_t;

  typedef struct packed {
    logic taken;
    logic call;
    logic ex;
    logic illegal;
  } jflags_t;
endpackage

// File: rtl/jru_decode.sv
module jru_decode
  import jru_pkg::*;
(
  input  logic [7:0] opcode,
  output jdec_t      dec
);
  logic [2:0] cls;
  logic       cls_ok;
  logic       wide_only;
  logic       bad;

  always_comb begin
    cls       = opcode[2:0];
    cls_ok    = (cls == CLS_WIDE) || (cls == CLS_NARROW);
    wide_only = (opcode[7:4] == JC_ALWAYS) || (opcode[7:4] == JC_EXIT);
    bad       = !cls_ok || (opcode[7:4] > JC_LAST) ||
                ((cls == CLS_NARROW) && wide_only);

    dec.code      = opcode[7:4];
    dec.use_reg   = opcode[3];
    dec.narrow    = (cls == CLS_NARROW);
    dec.illegal   = bad;
    dec.is_call   = !bad && (opcode[7:4] == JC_CALL);
    dec.is_exit   = !bad && (opcode[7:4] == JC_EXIT);
    dec.is_always = !bad && (opcode[7:4] == JC_ALWAYS);
  end
endmodule

// File: rtl/jru_compare.sv
module jru_compare
  import jru_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int IMM_W    = 32
) (
  input  logic [3:0]        code,
  input  logic              narrow,
  input  logic              use_reg,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic [IMM_W-1:0]  imm,
  output logic              hit
);
  localparam int PAD_W = DATA_W - NARROW_W;

  function automatic logic [DATA_W-1:0] sext_imm(input logic [IMM_W-1:0] v);
    return {{(DATA_W-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [DATA_W-1:0] low_zext(input logic [DATA_W-1:0] v);
    return {{PAD_W{1'b0}}, v[NARROW_W-1:0]};
  endfunction

  function automatic logic [DATA_W-1:0] low_sext(input logic [DATA_W-1:0] v);
    return {{PAD_W{v[NARROW_W-1]}}, v[NARROW_W-1:0]};
  endfunction

  function automatic logic relation(input logic [3:0] c, input logic eq,
                                    input logic ltu, input logic lts,
                                    input logic any_and);
    case (c)
      JC_EQ:   return eq;
      JC_NE:   return !eq;
      JC_TEST: return any_and;
      JC_GTU:  return !ltu && !eq;
      JC_GEU:  return !ltu;
      JC_LTU:  return ltu;
      JC_LEU:  return ltu || eq;
      JC_GTS:  return !lts && !eq;
      JC_GES:  return !lts;
      JC_LTS:  return lts;
      JC_LES:  return lts || eq;
      default: return 1'b0;
    endcase
  endfunction

  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] a_u, b_u, a_s, b_s;
  logic              is_eq, is_ltu, is_lts, is_and;

  assign opnd_b = use_reg ? src_val : sext_imm(imm);

  generate
    if (PAD_W > 0) begin : g_split
      assign a_u = narrow ? low_zext(dst_val) : dst_val;
      assign b_u = narrow ? low_zext(opnd_b)  : opnd_b;
      assign a_s = narrow ? low_sext(dst_val) : dst_val;
      assign b_s = narrow ? low_sext(opnd_b)  : opnd_b;
    end else begin : g_same
      assign a_u = dst_val;
      assign b_u = opnd_b;
      assign a_s = dst_val;
      assign b_s = opnd_b;
    end
  endgenerate

  always_comb begin
    is_eq  = (a_u == b_u);
    is_ltu = (a_u < b_u);
    is_lts = ($signed(a_s) < $signed(b_s));
    is_and = |(a_u & b_u);
    hit    = relation(code, is_eq, is_ltu, is_lts, is_and);
  end
endmodule

// File: rtl/jru_target.sv
module jru_target #(
  parameter int PC_W  = 64,
  parameter int OFF_W = 16
) (
  input  logic [PC_W-1:0]  pc_in,
  input  logic [OFF_W-1:0] offset,
  output logic [PC_W-1:0]  seq_pc,
  output logic [PC_W-1:0]  br_pc
);
  function automatic logic [PC_W-1:0] widen_off(input logic [OFF_W-1:0] o);
    return {{(PC_W-OFF_W){o[OFF_W-1]}}, o};
  endfunction

  assign seq_pc = pc_in + {{(PC_W-1){1'b0}}, 1'b1};
  assign br_pc  = seq_pc + widen_off(offset);
endmodule

// File: rtl/jmp_resolve_unit.sv
module jmp_resolve_unit
  import jru_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int IMM_W    = 32,
  parameter int OFF_W    = 16,
  parameter int PC_W     = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [7:0]        opcode,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic [IMM_W-1:0]  imm,
  input  logic [OFF_W-1:0]  offset,
  input  logic [PC_W-1:0]   pc_in,
  output logic [PC_W-1:0]   next_pc,
  output logic              taken,
  output logic              call_req,
  output logic              exit_req,
  output logic              illegal
);
  jdec_t           dec;
  logic            cond_hit;
  logic            dec_illegal, dec_call, dec_exit, dec_uncond;
  logic [PC_W-1:0] seq_pc, br_pc, pc_d;
  jflags_t         fl_d, fl_q;
  logic [PC_W-1:0] pc_q;

  jru_decode u_dec (
    .opcode (opcode),
    .dec    (dec)
  );

  jru_compare #(
    .DATA_W   (DATA_W),
    .NARROW_W (NARROW_W),
    .IMM_W    (IMM_W)
  ) u_cmp (
    .code    (dec.code),
    .narrow  (dec.narrow),
    .use_reg (dec.use_reg),
    .dst_val (dst_val),
    .src_val (src_val),
    .imm     (imm),
    .hit     (cond_hit)
  );

  jru_target #(
    .PC_W  (PC_W),
    .OFF_W (OFF_W)
  ) u_tgt (
    .pc_in  (pc_in),
    .offset (offset),
    .seq_pc (seq_pc),
    .br_pc  (br_pc)
  );

  assign dec_illegal = dec.illegal;
  assign dec_call    = dec.is_call;
  assign dec_exit    = dec.is_exit;
  assign dec_uncond  = dec.is_always;

  always_comb begin
    fl_d.illegal = dec_illegal;
    fl_d.call    = dec_call;
    fl_d.ex      = dec_exit;
    fl_d.taken   = !dec_illegal && (dec_uncond || cond_hit);
    if (dec_illegal)     pc_d = pc_in;
    else if (fl_d.taken) pc_d = br_pc;
    else                 pc_d = seq_pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      fl_q <= '0;
    end else if (issue_valid) begin
      pc_q <= pc_d;
      fl_q <= fl_d;
    end else begin
      fl_q <= '0;
    end
  end

  assign next_pc  = pc_q;
  assign taken    = fl_q.taken;
  assign call_req = fl_q.call;
  assign exit_req = fl_q.ex;
  assign illegal  = fl_q.illegal;
endmodule

// File: rtl/jmp_resolve_unit_chk.sv
module jmp_resolve_unit_chk #(
  parameter int PC_W = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            issue_valid,
  input logic [7:0]      opcode,
  input logic [PC_W-1:0] pc_in,
  input logic [PC_W-1:0] next_pc,
  input logic            taken,
  input logic            call_req,
  input logic            exit_req,
  input logic            illegal,
  input logic            dec_illegal,
  input logic            dec_call,
  input logic            dec_uncond,
  input logic            cond_hit
);
  p_flags_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({taken, call_req, exit_req, illegal}));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> !taken && !call_req && !exit_req && !illegal);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> $stable(next_pc));

  p_illegal_pc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && dec_illegal |=> illegal && (next_pc == $past(pc_in)));

  p_narrow_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && (opcode == 8'h96) |=> illegal && !exit_req);

  p_seq_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && !dec_illegal && !cond_hit && !dec_uncond
      |=> !taken && (next_pc == $past(pc_in) + 1'b1));

  p_call_no_jump_r10: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && dec_call |=> call_req && !taken
      && (next_pc == $past(pc_in) + 1'b1));
endmodule

bind jmp_resolve_unit jmp_resolve_unit_chk #(.PC_W(PC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue_valid (issue_valid),
  .opcode      (opcode),
  .pc_in       (pc_in),
  .next_pc     (next_pc),
  .taken       (taken),
  .call_req    (call_req),
  .exit_req    (exit_req),
  .illegal     (illegal),
  .dec_illegal (dec_illegal),
  .dec_call    (dec_call),
  .dec_uncond  (dec_uncond),
  .cond_hit    (cond_hit)
);

// File: tb/jmp_resolve_unit_bench.sv
module jmp_resolve_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 33;

  typedef struct packed {
    logic [3:0]  req;
    logic [7:0]  op;
    logic [63:0] dst;
    logic [63:0] src;
    logic [31:0] imm;
    logic [15:0] off;
    logic [63:0] pc;
    logic [63:0] exp_pc;
    logic [3:0]  exp_fl;   // {taken, call, exit, illegal}
  } vec_t;

  localparam logic [63:0] ALL1 = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] TOPB = 64'h8000_0000_0000_0000;

  localparam vec_t VEC [NV] = '{
    '{4'd7,  8'h1D, 64'd7, 64'd7, 32'd0, 16'd5, 64'd100, 64'd106, 4'b1000}, // R7 eq hit
    '{4'd7,  8'h1D, 64'd7, 64'd8, 32'd0, 16'd5, 64'd100, 64'd101, 4'b0000}, // R7 eq miss
    '{4'd4,  8'h15, ALL1, 64'd0, 32'hFFFF_FFFF, 16'd5, 64'd100, 64'd106, 4'b1000}, // R4 sext imm
    '{4'd3,  8'h16, 64'h1_0000_0005, 64'd0, 32'd5, 16'd5, 64'd100, 64'd106, 4'b1000}, // R3 low half
    '{4'd3,  8'h1D, 64'h1_0000_0005, 64'd5, 32'd0, 16'd5, 64'd100, 64'd101, 4'b0000}, // R3 full width
    '{4'd5,  8'h2D, TOPB, 64'd1, 32'd0, 16'hFFFD, 64'd100, 64'd98, 4'b1000}, // R5 gtu, back
    '{4'd6,  8'h6D, TOPB, 64'd1, 32'd0, 16'hFFFD, 64'd100, 64'd101, 4'b0000}, // R6 gts
    '{4'd6,  8'h6E, 64'h8000_0000, 64'd1, 32'd0, 16'd5, 64'd100, 64'd101, 4'b0000}, // R6 narrow sign
    '{4'd5,  8'h2E, 64'h8000_0000, 64'd1, 32'd0, 16'd5, 64'd100, 64'd106, 4'b1000}, // R5 narrow
    '{4'd5,  8'h3D, 64'd3, 64'd3, 32'd0, 16'd5, 64'd100, 64'd106, 4'b1000}, // R5 geu equal
    '{4'd5,  8'hAD, 64'd2, 64'd3, 32'd0, 16'd5, 64'd100, 64'd106, 4'b1000}, // R5 ltu
    '{4'd5,  8'hBD, 64'd4, 64'd3, 32'd0, 16'd5, 64'd100, 64'd101, 4'b0000}, // R5 leu miss
    '{4'd6,  8'hCD, ALL1, 64'd0, 32'd0, 16'd5, 64'd100, 64'd106, 4'b1000}, // R6 lts
    '{4'd6,  8'hDD, 64'd0, 64'd0, 32'd0, 16'd5, 64'd100, 64'd106, 4'b1000}, // R6 les equal
    '{4'd6,  8'h7D, 64'hFFFF_FFFF_FFFF_FFFE, ALL1, 32'd0, 16'd5, 64'd100, 64'd101, 4'b0000}, // R6 ges
    '{4'd7,  8'h4D, 64'hF0, 64'h0F, 32'd0, 16'd5, 64'd100, 64'd101, 4'b0000}, // R7 test miss
    '{4'd7,  8'h4D, 64'h18, 64'h08, 32'd0, 16'd5, 64'd100, 64'd106, 4'b1000}, // R7 test hit
    '{4'd7,  8'h5D, 64'd1, 64'd2, 32'd0, 16'd5, 64'd100, 64'd106, 4'b1000}, // R7 ne
    '{4'd4,  8'h45, TOPB, 64'd0, 32'h8000_0000, 16'd5, 64'd100, 64'd106, 4'b1000}, // R4 imm sext
    '{4'd4,  8'h4D, TOPB, 64'd0, 32'h8000_0000, 16'd5, 64'd100, 64'd101, 4'b0000}, // R4 reg chosen
    '{4'd9,  8'h05, 64'd0, 64'd0, 32'd0, 16'd5, 64'd100, 64'd106, 4'b1000}, // R9 always
    '{4'd10, 8'h85, 64'd0, 64'd0, 32'd0, 16'd5, 64'd100, 64'd101, 4'b0100}, // R10 call
    '{4'd10, 8'h86, 64'd0, 64'd0, 32'd0, 16'd5, 64'd100, 64'd101, 4'b0100}, // R10 call narrow
    '{4'd10, 8'h95, 64'd0, 64'd0, 32'd0, 16'd5, 64'd100, 64'd101, 4'b0010}, // R10 exit
    '{4'd11, 8'h96, 64'd0, 64'd0, 32'd0, 16'd5, 64'd100, 64'd100, 4'b0001}, // R11 exit narrow
    '{4'd11, 8'h06, 64'd0, 64'd0, 32'd0, 16'd5, 64'd100, 64'd100, 4'b0001}, // R11 always narrow
    '{4'd11, 8'hE5, 64'd0, 64'd0, 32'd0, 16'd5, 64'd100, 64'd100, 4'b0001}, // R11 code 14
    '{4'd11, 8'hFD, 64'd0, 64'd0, 32'd0, 16'd5, 64'd100, 64'd100, 4'b0001}, // R11 code 15
    '{4'd11, 8'h14, 64'd0, 64'd0, 32'd0, 16'd5, 64'd100, 64'd100, 4'b0001}, // R11 class 4
    '{4'd8,  8'h05, 64'd0, 64'd0, 32'd0, 16'd0, ALL1, 64'd0, 4'b1000}, // R8 wrap up
    '{4'd8,  8'h05, 64'd0, 64'd0, 32'd0, 16'hFFFF, 64'd0, 64'd0, 4'b1000}, // R8 minus one
    '{4'd3,  8'h6E, 64'd2, 64'hFFFF_FFFF_0000_0001, 32'd0, 16'd5, 64'd100, 64'd106, 4'b1000}, // R3 narrow gts
    '{4'd4,  8'h66, 64'h0000_0000_FFFF_FFFF, 64'd0, 32'hFFFF_FFFE, 16'd5, 64'd100, 64'd106, 4'b1000} // R4 narrow imm
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic [7:0]  opcode = '0;
  logic [63:0] dst_val = '0, src_val = '0, pc_in = '0;
  logic [31:0] imm = '0;
  logic [15:0] offset = '0;
  logic [63:0] next_pc;
  logic        taken, call_req, exit_req, illegal;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jmp_resolve_unit u_jmp_resolve_unit (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .opcode(opcode),
    .dst_val(dst_val), .src_val(src_val), .imm(imm), .offset(offset),
    .pc_in(pc_in), .next_pc(next_pc), .taken(taken), .call_req(call_req),
    .exit_req(exit_req), .illegal(illegal)
  );

  task automatic check(input string tag, input logic [63:0] exp_pc,
                       input logic [3:0] exp_fl);
    logic [3:0] got;
    got = {taken, call_req, exit_req, illegal};
    checks++;
    if (next_pc !== exp_pc || got !== exp_fl) begin
      failures++;
      $display("FAIL %s: pc=%0h flags=%b expected pc=%0h flags=%b",
               tag, next_pc, got, exp_pc, exp_fl);
    end
  endtask

  task automatic issue(input vec_t v);
    opcode = v.op; dst_val = v.dst; src_val = v.src; imm = v.imm;
    offset = v.off; pc_in = v.pc; issue_valid = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset", 64'd0, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 idle after reset", 64'd0, 4'b0000);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i]);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].exp_pc, VEC[i].exp_fl);
    end

    // R2: flags drop and next_pc holds when nothing is issued
    issue_valid = 1'b0;
    opcode = 8'h05; offset = 16'd40; pc_in = 64'd7;
    @(negedge clk);
    check("R2 pulse ends", VEC[NV-1].exp_pc, 4'b0000);
    @(negedge clk);
    check("R2 hold", VEC[NV-1].exp_pc, 4'b0000);

    // R10 back-to-back: exit followed by call, pulse each cycle
    issue('{4'd10, 8'h95, 64'd0, 64'd0, 32'd0, 16'd0, 64'd200, 64'd201, 4'b0010});
    check("R10 exit b2b", 64'd201, 4'b0010);
    issue('{4'd10, 8'h8D, 64'd0, 64'd0, 32'd0, 16'd0, 64'd300, 64'd301, 4'b0100});
    check("R10 call b2b", 64'd301, 4'b0100);
    issue_valid = 1'b0;

    // R1: reset mid-run clears outputs
    rst_n = 1'b0;
    #1;
    check("R1 reset again", 64'd0, 4'b0000);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule